// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services a translation-cache miss by walking a two-level page table held in memory. A miss arrives as a virtual page number together with a mask of the access rights the faulting access needs. The walker splits the page number into a directory index (upper bits) and a table index (lower bits). It reads one directory entry, and only when that entry is valid does it read one table entry from the page the directory entry points to.

The walk ends in one of two ways. If the table entry is usable, the walker presents an insert (page number, frame number, rights) for one cycle and signals a retry in the following cycle. Otherwise it reports a fault code for one cycle. A missing directory entry therefore costs a single memory read before the fault.

The memory port is a one-cycle request with an address, answered by a data-valid pulse after any number of cycles. In the default geometry, virtual addresses are 14 bits with 64-byte pages, which gives an 8-bit page number split 4/4. Physical addresses are 16 bits, which gives 10-bit frame numbers, and table entries are 4 bytes.

Top module: `tlb_refill_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, mem_req, tlb_ins, retry and fault are all 0 and fault_code is 00.
- R2: A miss is taken only while busy is 0. Any miss_valid, miss_vpn or miss_need activity while busy is 1 leaves the addresses and the outcome of the walk in progress unchanged.
- R3: In the cycle after a miss is taken, mem_req is 1 for exactly one cycle. mem_addr is then (dir_base + vpn[7:4]*4) modulo 2^16.
- R4: If bit 0 (valid) of the directory entry is 0, the cycle after its response shows fault=1 with fault_code=01 (segmentation). No second memory request follows.
- R5: If the directory entry is valid, the cycle after its response shows mem_req=1 with mem_addr = (entry[17:8] << 6) + vpn[3:0]*4.
- R6: A table entry with bit 0 equal to 0 ends the walk with fault=1 and fault_code=01 in the cycle after its response.
- R7: Rights are held in entry bits [3:1] as {execute, write, read}, and miss_need uses the same order in bits [2:0]. A valid table entry that lacks any needed right ends the walk with fault=1, fault_code=10 (protection) and no insert.
- R8: A valid, permitted table entry gives tlb_ins=1 for one cycle, in the cycle after its response. In that cycle tlb_vpn is the miss page number, tlb_pfn is entry[17:8] and tlb_prot is entry[3:1]. retry=1 follows in the next cycle only. fault and tlb_ins are never 1 together.
- R9: busy is 1 from the cycle after a miss is taken through the cycle that shows the insert or the fault, and 0 otherwise.
- R10: While a read is outstanding, the walker waits for any number of cycles with mem_req at 0 and busy at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 16 | Physical byte address of the page directory, sampled when a miss is taken |
| miss_valid | input | 1 | A miss is offered |
| miss_vpn | input | 8 | Virtual page number of the miss |
| miss_need | input | 3 | Rights required {execute, write, read} |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 16 | Byte address of the requested entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry word returned by memory |
| tlb_ins | output | 1 | Insert strobe for the translation cache |
| tlb_vpn | output | 8 | Page number to insert |
| tlb_pfn | output | 10 | Frame number to insert |
| tlb_prot | output | 3 | Rights to insert {execute, write, read} |
| retry | output | 1 | Retry the faulting access (cycle after insert) |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 2 | 01 segmentation, 10 protection, 00 otherwise |

## Verification
The assertions take for granted that memory answers each request with exactly one mem_rvalid pulse. They also assume the pulse arrives only while the walker is waiting, no earlier than the cycle after the request, and that mem_rdata is meaningful only alongside it. The stimulus drives the response pulse only inside the wait window, after a chosen latency of one or more cycles, and keeps mem_rvalid low at every other time. Miss inputs are left free while busy, and one walk deliberately toggles them there to show they are ignored.

// File: rtl/walk_pkg.sv
package walk_pkg;

   typedef enum logic [2:0] {
      W_IDLE    = 3'd0,
      W_RD_DIR  = 3'd1,
      W_WT_DIR  = 3'd2,
      W_RD_TBL  = 3'd3,
      W_WT_TBL  = 3'd4,
      W_INSERT  = 3'd5,
      W_FAULT   = 3'd6
   } walk_state_e;

   localparam logic [1:0] FLT_NONE = 2'b00;
   localparam logic [1:0] FLT_SEG  = 2'b01;
   localparam logic [1:0] FLT_PROT = 2'b10;

endpackage

// File: rtl/walk_addr_gen.sv
module walk_addr_gen #(
   parameter int PA_W        = 16,
   parameter int OFF_W       = 6,
   parameter int PDI_W       = 4,
   parameter int PTI_W       = 4,
   parameter int ENTRY_BYTES = 4,
   localparam int PFN_W      = PA_W - OFF_W,
   localparam int VPN_W      = PDI_W + PTI_W
) (
   input  logic [PA_W-1:0]  dir_base,
   input  logic [VPN_W-1:0] vpn,
   input  logic [PFN_W-1:0] dir_pfn,
   input  logic             sel_tbl,
   output logic [PA_W-1:0]  addr
);
   localparam int ESH = $clog2(ENTRY_BYTES);

   logic [PDI_W-1:0] pdi;
   logic [PTI_W-1:0] pti;
   logic [PA_W-1:0]  dir_off;
   logic [PA_W-1:0]  tbl_off;
   logic [PA_W-1:0]  tbl_base;

   assign pdi = vpn[VPN_W-1 -: PDI_W];
   assign pti = vpn[PTI_W-1:0];

   if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0) begin : g_shift
      assign dir_off = PA_W'(pdi) << ESH;
      assign tbl_off = PA_W'(pti) << ESH;
   end else begin : g_mul
      assign dir_off = PA_W'(pdi) * PA_W'(ENTRY_BYTES);
      assign tbl_off = PA_W'(pti) * PA_W'(ENTRY_BYTES);
   end

   assign tbl_base = {dir_pfn, {OFF_W{1'b0}}};
   assign addr     = sel_tbl ? (tbl_base + tbl_off) : (dir_base + dir_off);

   if (((1 << PTI_W) * ENTRY_BYTES) > (1 << OFF_W)) begin : g_bad_tbl
      $error("walk_addr_gen: a page table does not fit in one page");
   end
   if (OFF_W >= PA_W) begin : g_bad_off
      $error("walk_addr_gen: page offset wider than physical address");
   end

endmodule

// File: rtl/walk_entry_dec.sv
module walk_entry_dec #(
   parameter int DW      = 32,
   parameter int PROT_W  = 3,
   parameter int PFN_W   = 10,
   parameter int PFN_LSB = 8
) (
   input  logic [DW-1:0]     word,
   input  logic [PROT_W-1:0] need,
   output logic              ent_valid,
   output logic [PROT_W-1:0] ent_prot,
   output logic [PFN_W-1:0]  ent_pfn,
   output logic              ent_allow
);
   logic unused_rsvd;

   assign ent_valid   = word[0];
   assign ent_prot    = word[PROT_W:1];
   assign ent_pfn     = word[PFN_LSB +: PFN_W];
   assign ent_allow   = ((need & ~ent_prot) == '0);
   assign unused_rsvd = ^word;

   if (PFN_LSB + PFN_W > DW) begin : g_bad_pfn
      $error("walk_entry_dec: frame field exceeds entry word");
   end
   if (PROT_W + 1 > PFN_LSB) begin : g_bad_prot
      $error("walk_entry_dec: rights field overlaps frame field");
   end

endmodule

// File: rtl/walk_seq.sv
module walk_seq
   import walk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        miss_valid,
   input  logic        rvalid,
   input  logic        ent_valid,
   input  logic        ent_allow,
   output walk_state_e st,
   output logic [1:0]  code
);
   walk_state_e nxt;
   logic [1:0]  code_nxt;

   always_comb begin
      nxt      = st;
      code_nxt = code;
      case (st)
         W_IDLE:   if (miss_valid) begin
                      nxt      = W_RD_DIR;
                      code_nxt = FLT_NONE;
                   end
         W_RD_DIR: nxt = W_WT_DIR;
         W_WT_DIR: if (rvalid) begin
                      if (ent_valid) nxt = W_RD_TBL;
                      else begin
                         nxt      = W_FAULT;
                         code_nxt = FLT_SEG;
                      end
                   end
         W_RD_TBL: nxt = W_WT_TBL;
         W_WT_TBL: if (rvalid) begin
                      if (!ent_valid) begin
                         nxt      = W_FAULT;
                         code_nxt = FLT_SEG;
                      end else if (!ent_allow) begin
                         nxt      = W_FAULT;
                         code_nxt = FLT_PROT;
                      end else nxt = W_INSERT;
                   end
         W_INSERT: nxt = W_IDLE;
         W_FAULT:  nxt = W_IDLE;
         default:  nxt = W_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= W_IDLE;
         code <= FLT_NONE;
      end else begin
         st   <= nxt;
         code <= code_nxt;
      end
   end

   // R10: a wait state without a response holds
   p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == W_WT_DIR || st == W_WT_TBL) && !rvalid) |=> $stable(st));

   // R4: an invalid directory response leads straight to a segmentation fault
   p_dir_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_WT_DIR && rvalid && !ent_valid) |=> (st == W_FAULT && code == FLT_SEG));

endmodule

// File: rtl/tlb_refill_walker.sv
module tlb_refill_walker
   import walk_pkg::*;
#(
   parameter int PA_W        = 16,
   parameter int OFF_W       = 6,
   parameter int PDI_W       = 4,
   parameter int PTI_W       = 4,
   parameter int ENTRY_BYTES = 4,
   parameter int DW          = 32,
   parameter int PROT_W      = 3,
   parameter int PFN_LSB     = 8,
   localparam int PFN_W      = PA_W - OFF_W,
   localparam int VPN_W      = PDI_W + PTI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PA_W-1:0]   dir_base,
   input  logic              miss_valid,
   input  logic [VPN_W-1:0]  miss_vpn,
   input  logic [PROT_W-1:0] miss_need,
   output logic              busy,
   output logic              mem_req,
   output logic [PA_W-1:0]   mem_addr,
   input  logic              mem_rvalid,
   input  logic [DW-1:0]     mem_rdata,
   output logic              tlb_ins,
   output logic [VPN_W-1:0]  tlb_vpn,
   output logic [PFN_W-1:0]  tlb_pfn,
   output logic [PROT_W-1:0] tlb_prot,
   output logic              retry,
   output logic              fault,
   output logic [1:0]        fault_code
);
   walk_state_e       st;
   logic [1:0]        code;
   logic              accept;
   logic [VPN_W-1:0]  vpn_q;
   logic [PROT_W-1:0] need_q;
   logic [PA_W-1:0]   base_q;
   logic [PFN_W-1:0]  dir_pfn_q;
   logic [PFN_W-1:0]  pfn_q;
   logic [PROT_W-1:0] prot_q;
   logic              retry_q;
   logic              ent_valid;
   logic              ent_allow;
   logic [PROT_W-1:0] ent_prot;
   logic [PFN_W-1:0]  ent_pfn;

   walk_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .rvalid     (mem_rvalid),
      .ent_valid  (ent_valid),
      .ent_allow  (ent_allow),
      .st         (st),
      .code       (code)
   );

   walk_entry_dec #(
      .DW      (DW),
      .PROT_W  (PROT_W),
      .PFN_W   (PFN_W),
      .PFN_LSB (PFN_LSB)
   ) u_dec (
      .word      (mem_rdata),
      .need      (need_q),
      .ent_valid (ent_valid),
      .ent_prot  (ent_prot),
      .ent_pfn   (ent_pfn),
      .ent_allow (ent_allow)
   );

   walk_addr_gen #(
      .PA_W        (PA_W),
      .OFF_W       (OFF_W),
      .PDI_W       (PDI_W),
      .PTI_W       (PTI_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_addr (
      .dir_base (base_q),
      .vpn      (vpn_q),
      .dir_pfn  (dir_pfn_q),
      .sel_tbl  (st == W_RD_TBL),
      .addr     (mem_addr)
   );

   assign accept = (st == W_IDLE) && miss_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q     <= '0;
         need_q    <= '0;
         base_q    <= '0;
         dir_pfn_q <= '0;
         pfn_q     <= '0;
         prot_q    <= '0;
         retry_q   <= 1'b0;
      end else begin
         retry_q <= (st == W_INSERT);
         if (accept) begin
            vpn_q  <= miss_vpn;
            need_q <= miss_need;
            base_q <= dir_base;
         end
         if (st == W_WT_DIR && mem_rvalid) dir_pfn_q <= ent_pfn;
         if (st == W_WT_TBL && mem_rvalid) begin
            pfn_q  <= ent_pfn;
            prot_q <= ent_prot;
         end
      end
   end

   assign busy       = (st != W_IDLE);
   assign mem_req    = (st == W_RD_DIR) || (st == W_RD_TBL);
   assign tlb_ins    = (st == W_INSERT);
   assign tlb_vpn    = vpn_q;
   assign tlb_pfn    = pfn_q;
   assign tlb_prot   = prot_q;
   assign retry      = retry_q;
   assign fault      = (st == W_FAULT);
   assign fault_code = fault ? code : FLT_NONE;

   // R10: requests only issue inside a walk
   p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R8: insert and fault are exclusive
   p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(tlb_ins && fault));

   // R8: retry follows the insert, and the walker is free by then
   p_retry_after_ins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_ins |=> (retry && !busy && !tlb_ins));

   // R9: taking a miss raises busy and issues the directory request
   p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && miss_valid) |=> (busy && mem_req));

   // R6: a reported fault always carries a defined code
   p_fault_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (fault_code == FLT_SEG || fault_code == FLT_PROT));

   // R7: a rights-denied table entry never produces an insert
   p_prot_no_ins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_WT_TBL && mem_rvalid && ent_valid && !ent_allow) |=> (!tlb_ins && fault_code == FLT_PROT));

   // R4: no request follows a reported fault
   p_no_req_after_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !mem_req);

endmodule

// File: tb/test_tlb_refill_walker.sv
module test_tlb_refill_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] dir_base = '0;
   logic        miss_valid = 1'b0;
   logic [7:0]  miss_vpn = '0;
   logic [2:0]  miss_need = '0;
   logic        busy;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        tlb_ins;
   logic [7:0]  tlb_vpn;
   logic [9:0]  tlb_pfn;
   logic [2:0]  tlb_prot;
   logic        retry;
   logic        fault;
   logic [1:0]  fault_code;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [31:0] mem [int];

   always #2.5 clk = ~clk;

   tlb_refill_walker i_tlb_refill_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .dir_base   (dir_base),
      .miss_valid (miss_valid),
      .miss_vpn   (miss_vpn),
      .miss_need  (miss_need),
      .busy       (busy),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .tlb_ins    (tlb_ins),
      .tlb_vpn    (tlb_vpn),
      .tlb_pfn    (tlb_pfn),
      .tlb_prot   (tlb_prot),
      .retry      (retry),
      .fault      (fault),
      .fault_code (fault_code)
   );

   function automatic logic [31:0] ent(bit v, logic [2:0] p, logic [9:0] f);
      return {14'b0, f, 4'b0, p, v};
   endfunction

   function automatic logic [31:0] rd(logic [15:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return 32'h0;
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic walk(logic [7:0] vpn, logic [2:0] need, logic [15:0] base,
                       int lat1, int lat2, bit noise);
      logic [15:0] pde_a, pte_a;
      logic [31:0] pde, pte;
      bit          ok;
      pde_a = 16'(base + 16'(vpn[7:4]) * 16'd4);
      pde   = rd(pde_a);
      pte_a = 16'({pde[17:8], 6'b0} + 16'(vpn[3:0]) * 16'd4);
      pte   = rd(pte_a);
      ok    = ((need & ~pte[3:1]) == 3'b0);

      @(negedge clk);
      chk("R9", "busy before miss", busy, 0);
      miss_valid = 1'b1; miss_vpn = vpn; miss_need = need; dir_base = base;
      @(negedge clk);
      if (noise) begin
         miss_vpn = ~vpn; miss_need = ~need; dir_base = ~base;
      end else miss_valid = 1'b0;
      chk("R3", "dir req", mem_req, 1);
      chk("R3", "dir addr", mem_addr, pde_a);
      chk("R9", "busy after accept", busy, 1);
      @(negedge clk);
      for (int i = 1; i < lat1; i++) begin
         chk("R10", "no req while waiting dir", mem_req, 0);
         chk("R10", "busy while waiting dir", busy, 1);
         @(negedge clk);
      end
      miss_valid = 1'b0;
      mem_rvalid = 1'b1; mem_rdata = pde;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = 32'h0;
      if (!pde[0]) begin
         chk("R4", "fault after bad dir", fault, 1);
         chk("R4", "seg code", fault_code, 1);
         chk("R4", "no second req", mem_req, 0);
         @(negedge clk);
         chk("R4", "no req after fault", mem_req, 0);
         chk("R9", "busy after fault", busy, 0);
         chk("R4", "fault one cycle", fault, 0);
         return;
      end
      chk("R5", "tbl req", mem_req, 1);
      chk("R5", "tbl addr", mem_addr, pte_a);
      @(negedge clk);
      for (int i = 1; i < lat2; i++) begin
         chk("R10", "no req while waiting tbl", mem_req, 0);
         chk("R10", "busy while waiting tbl", busy, 1);
         @(negedge clk);
      end
      mem_rvalid = 1'b1; mem_rdata = pte;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = 32'h0;
      if (!pte[0]) begin
         chk("R6", "fault on bad entry", fault, 1);
         chk("R6", "seg code", fault_code, 1);
         chk("R6", "no insert", tlb_ins, 0);
      end else if (!ok) begin
         chk("R7", "fault on rights", fault, 1);
         chk("R7", "prot code", fault_code, 2);
         chk("R7", "no insert", tlb_ins, 0);
      end else begin
         chk("R8", "insert", tlb_ins, 1);
         chk("R8", "fault low", fault, 0);
         chk("R8", "vpn", tlb_vpn, vpn);
         chk("R8", "pfn", tlb_pfn, pte[17:8]);
         chk("R8", "prot", tlb_prot, pte[3:1]);
         chk("R8", "no early retry", retry, 0);
         chk("R9", "busy at insert", busy, 1);
      end
      @(negedge clk);
      chk("R9", "busy after end", busy, 0);
      chk("R8", "retry after insert", retry, (pte[0] && ok) ? 1 : 0);
      chk("R8", "single insert", tlb_ins, 0);
      chk("R6", "fault one cycle", fault, 0);
      @(negedge clk);
      chk("R8", "retry one cycle", retry, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      mem[16'h1008] = ent(1'b1, 3'b000, 10'h050);
      mem[16'h140C] = ent(1'b1, 3'b001, 10'h3A5);
      mem[16'h143C] = ent(1'b1, 3'b011, 10'h2B7);
      mem[16'h001C] = ent(1'b1, 3'b000, 10'h3FF);
      mem[16'hFFC4] = ent(1'b1, 3'b111, 10'h001);

      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", busy, 0);
      chk("R1", "req in reset", mem_req, 0);
      chk("R1", "ins in reset", tlb_ins, 0);
      chk("R1", "retry in reset", retry, 0);
      chk("R1", "fault in reset", fault, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "code after reset", fault_code, 0);

      walk(8'h23, 3'b001, 16'h1000, 1, 1, 1'b0); // R8 read hit
      walk(8'h2F, 3'b010, 16'h1000, 3, 5, 1'b0); // R8 R10 long latency
      walk(8'h50, 3'b001, 16'h1000, 2, 1, 1'b0); // R4 missing directory
      walk(8'h27, 3'b001, 16'h1000, 1, 2, 1'b0); // R6 missing table entry
      walk(8'h23, 3'b010, 16'h1000, 1, 1, 1'b0); // R7 write denied
      walk(8'h2F, 3'b100, 16'h1000, 2, 2, 1'b0); // R7 execute denied
      walk(8'h2F, 3'b010, 16'h1000, 3, 2, 1'b1); // R2 inputs toggled while busy
      walk(8'hF1, 3'b111, 16'hFFE0, 1, 4, 1'b0); // R3 base wraps, R5 top frame
      walk(8'h23, 3'b000, 16'h1000, 1, 1, 1'b0); // R7 empty need always allowed

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule